// File: doc/BRIEF.md
# H-Bridge Mode Arbiter with Fault Latch

This block decides, every clock cycle, which of the four switches of one full bridge are turned on. The switches are the two high-side switches U1 and U2 and the two low-side switches L1 and L2. U1 and L1 form one leg, and U2 and L2 form the other. The block takes several inputs: the sleep, enable and brake controls, a direction source selector, a direction pin, a direction bit from a serial register, the present decay phase from the chopping timer, a thermal flag and an overcurrent comparator. It resolves them in a fixed priority and drives the four gate enables from a register.

Thermal and overcurrent events are held in latches, and a latched fault turns the whole bridge off. An overcurrent only counts as a fault when the comparator stays high for a programmed number of consecutive cycles. This matches roughly half a chopping period. The latches are released by one event only: a complete low, then high, then low sequence on the sleep input that ends after the fault was latched.

Top module: `hb_mode_arbiter`

## Requirements
- R1: While `rst_n` is low, `gate_en` is 4'b0000 and `fault_stat` is 2'b00. All outputs are registered, so each one reflects the inputs sampled at the preceding rising clock edge.
- R2: With `sleep_n` sampled low, `gate_en` is 4'b0000 regardless of every other input.
- R3: With `sleep_n` high and `enable` low, `gate_en` is 4'b0000 regardless of brake, direction and decay.
- R4: With `sleep_n`, `enable` and `brake` high and no fault, `gate_en` is 4'b0011 (L1 and L2 on, U1 and U2 off), regardless of direction and decay.
- R5: When driving, `mode_sel` low takes the direction from `phase_pin` and `mode_sel` high takes it from `ser_phase`. A value of 1 means forward and 0 means reverse.
- R6: `gate_en` bits are {U1,U2,L1,L2}. `decay_sel` is coded as 00 charge, 01 slow, 10 fast and 11 slow. In the forward direction, charge gives 4'b1001, slow gives 4'b0011 and fast gives 4'b0110.
- R7: In the reverse direction, charge gives 4'b0110, slow gives 4'b0011 and fast gives 4'b1001.
- R8: A `therm_flag` sampled high sets `fault_stat[0]`. From that same edge on, `gate_en` is 4'b0000 for as long as any fault bit is set.
- R9: `oc_cmp` high for OC_PERSIST_CYC consecutive samples (default 8) sets `fault_stat[1]` and turns the bridge off on that edge. A shorter run has no effect, and a low sample restarts the count.
- R10: Fault bits are cleared only at the edge where `sleep_n` is sampled low after a low-to-high transition that happened while a fault was latched. A high-to-low transition with no such preceding rise leaves the faults set.
- R11: The thermal detection has no hysteresis. A `therm_flag` still high at the clearing edge keeps `fault_stat[0]` set, so setting wins over clearing.
- R12: `gate_en` never has U1 together with L1, nor U2 together with L2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Low puts the bridge to sleep; pulse low-high-low to clear faults |
| enable | input | 1 | Low forces all switches off |
| brake | input | 1 | High applies low-side brake |
| mode_sel | input | 1 | Direction source: 0 pin, 1 serial bit |
| phase_pin | input | 1 | Direction pin, 1 forward |
| ser_phase | input | 1 | Direction bit from serial register, 1 forward |
| decay_sel | input | 2 | Decay phase from chopping timer |
| therm_flag | input | 1 | Over-temperature flag |
| oc_cmp | input | 1 | Overcurrent comparator output |
| gate_en | output | 4 | Switch enables {U1,U2,L1,L2} |
| fault_stat | output | 2 | Latched faults {overcurrent, thermal} |

## Verification
The bench goes after the priority ladder by applying brake together with disable and with sleep. An arbiter ranked in the wrong order would show 4'b0011 where all switches must be off. It runs an overcurrent burst one sample short of the trip count, then a full burst. A counter that does not restart, or that trips early, would latch a fault on the short run. The release sequence is tested both without a leading low phase and with the thermal flag still high at the clearing edge. A detector that reacts to any falling edge, or that lets clearing beat setting, would re-enable the bridge too early.

// File: rtl/hb_arb_pkg.sv
package hb_arb_pkg;

  typedef enum logic [1:0] {
    DEC_CHARGE = 2'b00,
    DEC_SLOW   = 2'b01,
    DEC_FAST   = 2'b10,
    DEC_RSVD   = 2'b11
  } decay_e;

  typedef enum logic [2:0] {
    BR_SLEEP,
    BR_FAULT,
    BR_OFF,
    BR_BRAKE,
    BR_DRIVE
  } br_state_e;

  // gate vector order {U1,U2,L1,L2}
  localparam int unsigned GATE_W   = 4;
  localparam logic [GATE_W-1:0] G_NONE   = 4'b0000;
  localparam logic [GATE_W-1:0] G_LOWS   = 4'b0011;
  localparam logic [GATE_W-1:0] G_DIAG_A = 4'b1001;
  localparam logic [GATE_W-1:0] G_DIAG_B = 4'b0110;

endpackage

// File: rtl/hb_fault_latch.sv
module hb_fault_latch
  import hb_arb_pkg::*;
#(
  parameter int unsigned OC_PERSIST_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  input  logic therm_flag,
  input  logic oc_cmp,
  output logic therm_lat,
  output logic oc_lat,
  output logic fault_now
);

  localparam int unsigned CW = (OC_PERSIST_CYC < 2) ? 1 : $clog2(OC_PERSIST_CYC);
  localparam logic [CW-1:0] TRIP = CW'(OC_PERSIST_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sleep_q;
  logic          arm_q, arm_d;
  logic          therm_d, oc_d;
  logic          oc_trip, rise, fall, clr;

  // persistence counter and edge detection on sleep_n
  always_comb begin
    oc_trip = sleep_n && oc_cmp && (cnt_q == TRIP);
    if (!sleep_n || !oc_cmp) begin
      cnt_d = '0;
    end else if (cnt_q != TRIP) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
    rise = sleep_n && !sleep_q;
    fall = !sleep_n && sleep_q;
    clr  = fall && arm_q;
  end

  // latch next state: setting wins over clearing
  always_comb begin
    therm_d = therm_flag || (therm_lat && !clr);
    oc_d    = oc_trip || (oc_lat && !clr);
    if (clr) begin
      arm_d = 1'b0;
    end else if (!(therm_lat || oc_lat)) begin
      arm_d = 1'b0;
    end else if (rise) begin
      arm_d = 1'b1;
    end else begin
      arm_d = arm_q;
    end
    fault_now = therm_flag || oc_trip || therm_lat || oc_lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sleep_q   <= 1'b0;
      arm_q     <= 1'b0;
      therm_lat <= 1'b0;
      oc_lat    <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      sleep_q   <= sleep_n;
      arm_q     <= arm_d;
      therm_lat <= therm_d;
      oc_lat    <= oc_d;
    end
  end

endmodule

// File: rtl/hb_mode_resolve.sv
module hb_mode_resolve
  import hb_arb_pkg::*;
(
  input  logic      sleep_n,
  input  logic      fault_now,
  input  logic      enable,
  input  logic      brake,
  input  logic      mode_sel,
  input  logic      phase_pin,
  input  logic      ser_phase,
  output br_state_e state,
  output logic      fwd
);

  always_comb begin
    fwd = mode_sel ? ser_phase : phase_pin;
    if (!sleep_n) begin
      state = BR_SLEEP;
    end else if (fault_now) begin
      state = BR_FAULT;
    end else if (!enable) begin
      state = BR_OFF;
    end else if (brake) begin
      state = BR_BRAKE;
    end else begin
      state = BR_DRIVE;
    end
  end

endmodule

// File: rtl/hb_gate_map.sv
module hb_gate_map
  import hb_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  br_state_e         state,
  input  logic              fwd,
  input  decay_e            decay,
  output logic [GATE_W-1:0] gate_q
);

  logic [GATE_W-1:0] gate_d;

  always_comb begin
    gate_d = G_NONE;
    case (state)
      BR_BRAKE: gate_d = G_LOWS;
      BR_DRIVE: begin
        case (decay)
          DEC_CHARGE: gate_d = fwd ? G_DIAG_A : G_DIAG_B;
          DEC_FAST:   gate_d = fwd ? G_DIAG_B : G_DIAG_A;
          default:    gate_d = G_LOWS;
        endcase
      end
      default: gate_d = G_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= G_NONE;
    end else begin
      gate_q <= gate_d;
    end
  end

endmodule

// File: rtl/hb_mode_arbiter.sv
module hb_mode_arbiter
  import hb_arb_pkg::*;
#(
  parameter int unsigned OC_PERSIST_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_n,
  input  logic       enable,
  input  logic       brake,
  input  logic       mode_sel,
  input  logic       phase_pin,
  input  logic       ser_phase,
  input  logic [1:0] decay_sel,
  input  logic       therm_flag,
  input  logic       oc_cmp,
  output logic [3:0] gate_en,
  output logic [1:0] fault_stat
);

  logic      therm_lat, oc_lat, fault_now, fwd;
  br_state_e state;
  decay_e    decay;

  assign decay = decay_e'(decay_sel);

  hb_fault_latch #(.OC_PERSIST_CYC(OC_PERSIST_CYC)) flt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_n    (sleep_n),
    .therm_flag (therm_flag),
    .oc_cmp     (oc_cmp),
    .therm_lat  (therm_lat),
    .oc_lat     (oc_lat),
    .fault_now  (fault_now)
  );

  hb_mode_resolve res_i (
    .sleep_n   (sleep_n),
    .fault_now (fault_now),
    .enable    (enable),
    .brake     (brake),
    .mode_sel  (mode_sel),
    .phase_pin (phase_pin),
    .ser_phase (ser_phase),
    .state     (state),
    .fwd       (fwd)
  );

  hb_gate_map map_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state),
    .fwd    (fwd),
    .decay  (decay),
    .gate_q (gate_en)
  );

  assign fault_stat = {oc_lat, therm_lat};

endmodule

// File: rtl/hb_mode_arbiter_chk.sv
module hb_mode_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_n,
  input logic       enable,
  input logic       brake,
  input logic       therm_flag,
  input logic [3:0] gate_en,
  input logic [1:0] fault_stat
);

  AST_NO_SHOOT_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en[3] && gate_en[1]) && !(gate_en[2] && gate_en[0])); // R12

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> (gate_en == 4'b0000)); // R2

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && !enable) |=> (gate_en == 4'b0000)); // R3

  AST_BRAKE_LOWSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sleep_n && enable && brake) && (fault_stat == 2'b00)) |-> (gate_en == 4'b0011)); // R4

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_stat != 2'b00) |-> (gate_en == 4'b0000)); // R8

  AST_THERM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    therm_flag |=> fault_stat[0]); // R11

  AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_stat[0]) |-> (!$past(sleep_n) && $past(sleep_n, 2))); // R10

endmodule

bind hb_mode_arbiter hb_mode_arbiter_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep_n    (sleep_n),
  .enable     (enable),
  .brake      (brake),
  .therm_flag (therm_flag),
  .gate_en    (gate_en),
  .fault_stat (fault_stat)
);

// File: tb/hb_mode_arbiter_tb_top.sv
`timescale 1ns/1ps
module hb_mode_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sleep_n, enable, brake, mode_sel, phase_pin, ser_phase;
  logic [1:0] decay_sel;
  logic       therm_flag, oc_cmp;
  logic [3:0] gate_en;
  logic [1:0] fault_stat;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [3:0] g;
    logic [1:0] f;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  hb_mode_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .enable(enable), .brake(brake),
    .mode_sel(mode_sel), .phase_pin(phase_pin), .ser_phase(ser_phase),
    .decay_sel(decay_sel), .therm_flag(therm_flag), .oc_cmp(oc_cmp),
    .gate_en(gate_en), .fault_stat(fault_stat)
  );

  task automatic compare(input logic [3:0] g, input logic [1:0] f, input string tag);
    checks++;
    if (gate_en !== g || fault_stat !== f) begin
      errors++;
      $display("FAIL %s: gate_en=%b fault_stat=%b expected gate_en=%b fault_stat=%b",
               tag, gate_en, fault_stat, g, f);
    end
  endtask

  // driver: one input vector per cycle, expected result queued
  task automatic step(input logic s, e, b, m, p, sp, input logic [1:0] d,
                      input logic th, oc, input logic [3:0] eg,
                      input logic [1:0] ef, input string tag);
    exp_t it;
    @(negedge clk);
    sleep_n = s; enable = e; brake = b; mode_sel = m; phase_pin = p;
    ser_phase = sp; decay_sel = d; therm_flag = th; oc_cmp = oc;
    it.g = eg; it.f = ef; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares after the edge that captured the vector
  always @(posedge clk) begin
    #3;
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      compare(it.g, it.f, it.tag);
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sleep_n = 1'b1; enable = 1'b1; brake = 1'b0; mode_sel = 1'b0;
    phase_pin = 1'b1; ser_phase = 1'b0; decay_sel = 2'b00;
    therm_flag = 1'b0; oc_cmp = 1'b0;
    repeat (3) @(posedge clk);
    #3 compare(4'b0000, 2'b00, "R1 reset");
    @(negedge clk);
    sleep_n = 1'b0;
    rst_n = 1'b1;

    //   s  e  b  m  p  sp d      th oc  gates    fault
    step(0, 1, 0, 0, 1, 0, 2'b00, 0, 0, 4'b0000, 2'b00, "R2 sleep");
    step(0, 1, 1, 0, 1, 0, 2'b00, 0, 0, 4'b0000, 2'b00, "R2 sleep over brake");
    step(1, 0, 1, 0, 1, 0, 2'b00, 0, 0, 4'b0000, 2'b00, "R3 disable over brake");
    step(1, 0, 0, 0, 1, 0, 2'b00, 0, 0, 4'b0000, 2'b00, "R3 disable");
    step(1, 1, 1, 0, 1, 0, 2'b00, 0, 0, 4'b0011, 2'b00, "R4 brake fwd charge");
    step(1, 1, 1, 0, 0, 0, 2'b10, 0, 0, 4'b0011, 2'b00, "R4 brake rev fast");
    step(1, 1, 0, 0, 1, 0, 2'b00, 0, 0, 4'b1001, 2'b00, "R6 fwd charge");
    step(1, 1, 0, 0, 1, 0, 2'b01, 0, 0, 4'b0011, 2'b00, "R6 fwd slow");
    step(1, 1, 0, 0, 1, 0, 2'b10, 0, 0, 4'b0110, 2'b00, "R6 fwd fast");
    step(1, 1, 0, 0, 1, 0, 2'b11, 0, 0, 4'b0011, 2'b00, "R6 code 11 slow");
    step(1, 1, 0, 0, 0, 0, 2'b00, 0, 0, 4'b0110, 2'b00, "R7 rev charge");
    step(1, 1, 0, 0, 0, 0, 2'b01, 0, 0, 4'b0011, 2'b00, "R7 rev slow");
    step(1, 1, 0, 0, 0, 0, 2'b10, 0, 0, 4'b1001, 2'b00, "R7 rev fast");
    step(1, 1, 0, 1, 1, 0, 2'b00, 0, 0, 4'b0110, 2'b00, "R5 serial rev");
    step(1, 1, 0, 1, 0, 1, 2'b00, 0, 0, 4'b1001, 2'b00, "R5 serial fwd");
    step(1, 1, 0, 1, 0, 1, 2'b10, 0, 0, 4'b0110, 2'b00, "R5 serial fwd fast");

    // overcurrent: short burst, restart, full burst
    for (int i = 0; i < 7; i++)
      step(1, 1, 0, 0, 1, 0, 2'b00, 0, 1, 4'b1001, 2'b00, "R9 short burst");
    step(1, 1, 0, 0, 1, 0, 2'b00, 0, 0, 4'b1001, 2'b00, "R9 restart");
    for (int i = 0; i < 7; i++)
      step(1, 1, 0, 0, 1, 0, 2'b00, 0, 1, 4'b1001, 2'b00, "R9 burst below trip");
    step(1, 1, 0, 0, 1, 0, 2'b00, 0, 1, 4'b0000, 2'b10, "R9 trip");
    step(1, 1, 0, 0, 1, 0, 2'b00, 0, 0, 4'b0000, 2'b10, "R10 oc held");
    step(0, 1, 0, 0, 1, 0, 2'b00, 0, 0, 4'b0000, 2'b10, "R10 fall without rise");
    step(1, 1, 0, 0, 1, 0, 2'b00, 0, 0, 4'b0000, 2'b10, "R10 rise");
    step(0, 1, 0, 0, 1, 0, 2'b00, 0, 0, 4'b0000, 2'b00, "R10 clear oc");
    step(1, 1, 0, 0, 1, 0, 2'b00, 0, 0, 4'b1001, 2'b00, "R10 drive after clear");

    // thermal: set, hold, no-hysteresis clear attempt, real clear
    step(1, 1, 0, 0, 1, 0, 2'b00, 1, 0, 4'b0000, 2'b01, "R8 thermal set");
    step(1, 1, 1, 0, 1, 0, 2'b00, 0, 0, 4'b0000, 2'b01, "R8 thermal held over brake");
    step(0, 1, 0, 0, 1, 0, 2'b00, 0, 0, 4'b0000, 2'b01, "R10 thermal fall only");
    step(1, 1, 0, 0, 1, 0, 2'b00, 1, 0, 4'b0000, 2'b01, "R11 rise flag high");
    step(0, 1, 0, 0, 1, 0, 2'b00, 1, 0, 4'b0000, 2'b01, "R11 set beats clear");
    step(1, 1, 0, 0, 1, 0, 2'b00, 0, 0, 4'b0000, 2'b01, "R11 still latched");
    step(0, 1, 0, 0, 1, 0, 2'b00, 0, 0, 4'b0000, 2'b00, "R10 thermal clear");
    step(1, 1, 0, 0, 0, 0, 2'b00, 0, 0, 4'b0110, 2'b00, "R12 drive rev after clear");

    repeat (3) @(posedge clk);
    #5;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule